// File: doc/BRIEF.md
# Page-Flipping Pixel Framebuffer

This block is a pixel memory in which every location stores exactly one pixel. The screen width, screen height and pixel depth are parameters, and a further parameter enables a second page. The CPU address width is not chosen directly. It follows from the pixel count: the low bits give the pixel offset within a page, and when the second page is enabled one extra top bit selects the page.

A CPU-side port writes and reads one pixel per access, with a fixed one-cycle read latency. A display-side scanner runs without stopping. It walks the shown page one pixel per clock, left to right and then top to bottom. It emits each pixel's raw value together with the colour that a fixed, built-in palette gives for that value.

A page-select input chooses the page on display. The scanner takes it only on the first pixel of each frame. Software therefore draws into the hidden page and flips the input when the drawing is complete, and the new page appears from the next frame on without tearing.

Top module: `pageflip_fb`

## Requirements
- R1: With the second page enabled, `cpu_addr` is ceil(log2(SCR_W*SCR_H))+1 bits wide. Bit AW-1 selects the page (0 lower, 1 upper) and the low bits give the pixel offset within that page.
- R2: A CPU write with `cpu_we`=1 stores `cpu_wdata` at the rising clock edge. A read presents `cpu_addr` and returns the stored pixel on `cpu_rdata` after that edge, so one cycle later.
- R3: If the pixel offset of `cpu_addr` is SCR_W*SCR_H or greater, a write has no effect on any stored pixel and a read returns 0.
- R4: After reset is released, the scanner covers pixel offsets 0 to SCR_W*SCR_H-1 in order, one per clock. `disp_x` counts from 0 to SCR_W-1 and then wraps while `disp_y` steps up by one. `disp_sof` is 1 only at x=0, y=0. Each result appears two rising edges after its offset is scanned, so `disp_valid` first rises on the second edge after reset is released.
- R5: `page_sel` is sampled only when the scanner is at offset 0. That page is reported on `disp_page` and is used for the whole frame, even if `page_sel` changes partway through the frame.
- R6: While page 0 is shown, CPU writes to page 1 never change `disp_pix`, and the reverse holds as well.
- R7: When the CPU writes a location in the same cycle that the scanner or a CPU read accesses it, the reader gets the value from before the write.
- R8: The palette is fixed, with `disp_rgb` = {red, green, blue} at 8 bits each. For PIX_BITS=1, value 0 is 000000h and value 1 is FFFFFFh. Otherwise, with M=2^PIX_BITS-1 and s(n)=n*255/M (integer division): red=s(v), green=s(v with its bits reversed), blue=s(M-v).
- R9: While `rst` is high, `disp_valid` and `cpu_rdata` are 0 from the next edge on, and scanning restarts at offset 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Page bit and pixel offset |
| cpu_we | input | 1 | Write enable |
| cpu_wdata | input | PIX_BITS | Pixel to write |
| cpu_rdata | output | PIX_BITS | Pixel read, one cycle latency |
| page_sel | input | 1 | Requested page for display |
| disp_valid | output | 1 | Display outputs are valid |
| disp_sof | output | 1 | First pixel of a frame |
| disp_x | output | XW | Column of the pixel |
| disp_y | output | YW | Row of the pixel |
| disp_page | output | 1 | Page the current frame is drawn from |
| disp_pix | output | PIX_BITS | Raw pixel value |
| disp_rgb | output | 24 | Palette colour of the pixel |

## Verification
The bench builds the block as a 6 by 5 screen with 2-bit pixels and both pages. A pixel count of 30 is not a power of two, so offsets 30 and 31 in each page exist as addresses but have no storage behind them, which brings the ignore-and-read-zero rule within reach. With 2-bit pixels the bit-reversed green channel yields colours that differ from a plain ramp. The short 30-cycle frame lets many frames pass, with page flips requested both at frame starts and in the middle of frames, alongside dense random writes that collide with the scanner.

// File: rtl/fb_pkg.sv
package fb_pkg;

  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // fixed colour rule: mono for one bit, else three derived ramps
  function automatic logic [23:0] fixed_colour(input int unsigned v,
                                               input int unsigned pb);
    int unsigned top;
    int unsigned rev;
    int unsigned r, g, b;
    if (pb == 1) begin
      return (v != 0) ? 24'hFFFFFF : 24'h000000;
    end
    top = (1 << pb) - 1;
    rev = 0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(pb)) rev = rev | (((v >> i) & 1) << (pb - 1 - i));
    end
    r = (v * 255) / top;
    g = (rev * 255) / top;
    b = ((top - v) * 255) / top;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

endpackage

// File: rtl/fb_scan.sv
module fb_scan
  import fb_pkg::*;
#(
  parameter int unsigned SCR_W = 6,
  parameter int unsigned SCR_H = 5,
  localparam int unsigned NPIX = SCR_W * SCR_H,
  localparam int unsigned PGW  = width_of(NPIX),
  localparam int unsigned XW   = width_of(SCR_W),
  localparam int unsigned YW   = width_of(SCR_H)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           page_req,
  output logic [PGW-1:0] scan_pos,
  output logic [XW-1:0]  scan_x,
  output logic [YW-1:0]  scan_y,
  output logic           scan_sof,
  output logic           scan_page
);

  logic [PGW-1:0] pos_q;
  logic [XW-1:0]  x_q;
  logic [YW-1:0]  y_q;
  logic           held_page_q;
  logic           at_start;
  logic           at_end;

  assign at_start  = (pos_q == '0);
  assign at_end    = (pos_q == PGW'(NPIX - 1));
  assign scan_page = at_start ? page_req : held_page_q;
  assign scan_pos  = pos_q;
  assign scan_x    = x_q;
  assign scan_y    = y_q;
  assign scan_sof  = at_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      x_q         <= '0;
      y_q         <= '0;
      held_page_q <= 1'b0;
    end else begin
      held_page_q <= scan_page;
      if (at_end) begin
        pos_q <= '0;
        x_q   <= '0;
        y_q   <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
        if (x_q == XW'(SCR_W - 1)) begin
          x_q <= '0;
          y_q <= y_q + 1'b1;
        end else begin
          x_q <= x_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fb_store.sv
module fb_store #(
  parameter int unsigned DEPTH = 60,
  parameter int unsigned PB    = 2,
  parameter int unsigned IW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PB-1:0] wr_data,
  input  logic [IW-1:0] cpu_idx,
  input  logic          cpu_ok,
  output logic [PB-1:0] cpu_data,
  input  logic [IW-1:0] dsp_idx,
  output logic [PB-1:0] dsp_data
);

  logic [PB-1:0] mem [DEPTH];
  logic [PB-1:0] cpu_raw_q;
  logic          cpu_ok_q;

  // read-first: both read ports see the contents before this edge's write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    dsp_data  <= mem[dsp_idx];
    cpu_raw_q <= mem[cpu_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_ok_q <= 1'b0;
    else     cpu_ok_q <= cpu_ok;
  end

  assign cpu_data = cpu_ok_q ? cpu_raw_q : '0;

endmodule

// File: rtl/fb_colour_stage.sv
module fb_colour_stage
  import fb_pkg::*;
#(
  parameter int unsigned PB = 2,
  parameter int unsigned XW = 3,
  parameter int unsigned YW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic          in_page,
  input  logic [PB-1:0] in_pix,
  output logic          out_valid,
  output logic          out_sof,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic          out_page,
  output logic [PB-1:0] out_pix,
  output logic [23:0]   out_rgb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_page  <= 1'b0;
      out_pix   <= '0;
      out_rgb   <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_sof;
      out_x     <= in_x;
      out_y     <= in_y;
      out_page  <= in_page;
      out_pix   <= in_pix;
      out_rgb   <= fixed_colour(int'(in_pix), PB);
    end
  end

endmodule

// File: rtl/pageflip_fb.sv
module pageflip_fb
  import fb_pkg::*;
#(
  parameter int unsigned SCR_W     = 6,
  parameter int unsigned SCR_H     = 5,
  parameter int unsigned PIX_BITS  = 2,
  parameter int unsigned DUAL_PAGE = 1,
  localparam int unsigned NPIX  = SCR_W * SCR_H,
  localparam int unsigned PGW   = width_of(NPIX),
  localparam int unsigned AW    = PGW + DUAL_PAGE,
  localparam int unsigned XW    = width_of(SCR_W),
  localparam int unsigned YW    = width_of(SCR_H)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       cpu_addr,
  input  logic                cpu_we,
  input  logic [PIX_BITS-1:0] cpu_wdata,
  output logic [PIX_BITS-1:0] cpu_rdata,
  input  logic                page_sel,
  output logic                disp_valid,
  output logic                disp_sof,
  output logic [XW-1:0]       disp_x,
  output logic [YW-1:0]       disp_y,
  output logic                disp_page,
  output logic [PIX_BITS-1:0] disp_pix,
  output logic [23:0]         disp_rgb
);

  localparam int unsigned PAGES = 1 + DUAL_PAGE;
  localparam int unsigned DEPTH = NPIX * PAGES;
  localparam int unsigned IW    = width_of(DEPTH);

  // CPU address decode
  logic [PGW-1:0] cpu_off;
  logic           cpu_pg;
  logic           cpu_ok;
  logic [IW-1:0]  cpu_idx;

  assign cpu_off = cpu_addr[PGW-1:0];

  generate
    if (DUAL_PAGE != 0) begin : g_cpu_page
      assign cpu_pg = cpu_addr[AW-1];
    end else begin : g_cpu_single
      assign cpu_pg = 1'b0;
    end
  endgenerate

  assign cpu_ok  = (int'(cpu_off) < int'(NPIX));
  assign cpu_idx = cpu_ok ? (IW'(cpu_off) + (cpu_pg ? IW'(NPIX) : '0)) : '0;

  // raster scanner
  logic [PGW-1:0] sc_pos;
  logic [XW-1:0]  sc_x;
  logic [YW-1:0]  sc_y;
  logic           sc_sof;
  logic           sc_page;
  logic           sc_pg_used;
  logic [IW-1:0]  dsp_idx;

  fb_scan #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .page_req (page_sel),
    .scan_pos (sc_pos),
    .scan_x   (sc_x),
    .scan_y   (sc_y),
    .scan_sof (sc_sof),
    .scan_page(sc_page)
  );

  generate
    if (DUAL_PAGE != 0) begin : g_dsp_page
      assign sc_pg_used = sc_page;
    end else begin : g_dsp_single
      assign sc_pg_used = 1'b0;
    end
  endgenerate

  assign dsp_idx = IW'(sc_pos) + (sc_pg_used ? IW'(NPIX) : '0);

  // storage
  logic [PIX_BITS-1:0] dsp_data;

  fb_store #(.DEPTH(DEPTH), .PB(PIX_BITS), .IW(IW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_we && cpu_ok),
    .wr_idx  (cpu_idx),
    .wr_data (cpu_wdata),
    .cpu_idx (cpu_idx),
    .cpu_ok  (cpu_ok),
    .cpu_data(cpu_rdata),
    .dsp_idx (dsp_idx),
    .dsp_data(dsp_data)
  );

  // stage 1: position data aligned with the memory read
  logic          s1_valid;
  logic          s1_sof;
  logic [XW-1:0] s1_x;
  logic [YW-1:0] s1_y;
  logic          s1_page;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_page  <= 1'b0;
    end else begin
      s1_valid <= 1'b1;
      s1_sof   <= sc_sof;
      s1_x     <= sc_x;
      s1_y     <= sc_y;
      s1_page  <= sc_pg_used;
    end
  end

  // stage 2: palette and registered outputs
  fb_colour_stage #(.PB(PIX_BITS), .XW(XW), .YW(YW)) u_colour (
    .clk      (clk),
    .rst      (rst),
    .in_valid (s1_valid),
    .in_sof   (s1_sof),
    .in_x     (s1_x),
    .in_y     (s1_y),
    .in_page  (s1_page),
    .in_pix   (dsp_data),
    .out_valid(disp_valid),
    .out_sof  (disp_sof),
    .out_x    (disp_x),
    .out_y    (disp_y),
    .out_page (disp_page),
    .out_pix  (disp_pix),
    .out_rgb  (disp_rgb)
  );

endmodule

// File: rtl/fb_checker.sv
module fb_checker
  import fb_pkg::*;
#(
  parameter int unsigned SCR_W     = 6,
  parameter int unsigned SCR_H     = 5,
  parameter int unsigned PIX_BITS  = 2,
  parameter int unsigned DUAL_PAGE = 1,
  localparam int unsigned NPIX = SCR_W * SCR_H,
  localparam int unsigned PGW  = width_of(NPIX),
  localparam int unsigned AW   = PGW + DUAL_PAGE,
  localparam int unsigned XW   = width_of(SCR_W),
  localparam int unsigned YW   = width_of(SCR_H)
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       cpu_addr,
  input logic [PIX_BITS-1:0] cpu_rdata,
  input logic                disp_valid,
  input logic                disp_sof,
  input logic [XW-1:0]       disp_x,
  input logic [YW-1:0]       disp_y,
  input logic                disp_page,
  input logic [PIX_BITS-1:0] disp_pix,
  input logic [7:0]          disp_red
);

  logic off_bad;
  assign off_bad = (int'(cpu_addr[PGW-1:0]) >= int'(NPIX));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!disp_valid && cpu_rdata == '0));

  // R3
  no_storage_read_chk: assert property (@(posedge clk) disable iff (rst)
    off_bad |=> (cpu_rdata == '0));

  // R4
  sof_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_sof) |-> (disp_x == '0 && disp_y == '0));

  // R4
  column_step_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_x != XW'(SCR_W - 1)) |=>
      (disp_valid && disp_x == $past(disp_x) + 1'b1 && disp_y == $past(disp_y)));

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_x == XW'(SCR_W - 1) && disp_y == YW'(SCR_H - 1)) |=> disp_sof);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> (disp_sof || $stable(disp_page)));

  // R8
  red_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_pix == '0) |-> (disp_red == 8'h00));

  // R8
  red_full_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_pix == '1) |-> (disp_red == 8'hFF));

endmodule

bind pageflip_fb fb_checker #(
  .SCR_W(SCR_W), .SCR_H(SCR_H), .PIX_BITS(PIX_BITS), .DUAL_PAGE(DUAL_PAGE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata),
  .disp_valid(disp_valid),
  .disp_sof  (disp_sof),
  .disp_x    (disp_x),
  .disp_y    (disp_y),
  .disp_page (disp_page),
  .disp_pix  (disp_pix),
  .disp_red  (disp_rgb[23:16])
);

// File: tb/sim_pageflip_fb.sv
`timescale 1ns/1ps
module sim_pageflip_fb;
  import fb_pkg::*;

  localparam int W = 6;
  localparam int H = 5;
  localparam int PB = 2;
  localparam int NPIX = W * H;
  localparam int PGW = 5;
  localparam int AW = 6;
  localparam int XW = 3;
  localparam int YW = 3;
  localparam int SPAN = 1 << PGW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_we = 1'b0;
  logic [PB-1:0] cpu_wdata = '0;
  logic [PB-1:0] cpu_rdata;
  logic          page_sel = 1'b0;
  logic          disp_valid, disp_sof, disp_page;
  logic [XW-1:0] disp_x;
  logic [YW-1:0] disp_y;
  logic [PB-1:0] disp_pix;
  logic [23:0]   disp_rgb;

  always #10 clk = ~clk;

  pageflip_fb #(.SCR_W(W), .SCR_H(H), .PIX_BITS(PB), .DUAL_PAGE(1)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .page_sel(page_sel),
    .disp_valid(disp_valid), .disp_sof(disp_sof), .disp_x(disp_x),
    .disp_y(disp_y), .disp_page(disp_page), .disp_pix(disp_pix),
    .disp_rgb(disp_rgb)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;

  // reference colour straight from the rule in R8
  function automatic int ref_rgb(input int v);
    int rv, r, g, b;
    rv = ((v & 1) << 1) | ((v >> 1) & 1);
    r = v * 255 / 3;
    g = rv * 255 / 3;
    b = (3 - v) * 255 / 3;
    return (r << 16) | (g << 8) | b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  int    mm [2*NPIX];
  bit    kn [2*NPIX];
  int    m_pos = 0;
  int    m_cur = 0;
  bit    s1_v = 0, o_v = 0;
  int    s1_x, s1_y, s1_pg, s1_pix, o_x, o_y, o_pg, o_pix;
  bit    s1_sof, s1_kn, o_sof, o_kn;
  string s1_tag, o_tag;
  int    rd_exp = 0;
  bit    rd_kn = 0;
  string rd_tag = "R9";

  initial begin
    for (int i = 0; i < 2*NPIX; i++) begin
      mm[i] = 0;
      kn[i] = 0;
    end
  end

  always @(posedge clk) begin
    int eff, idx, off, pg, widx;
    cycles++;
    started = 1;
    if (rst) begin
      m_pos = 0; m_cur = 0; s1_v = 0; o_v = 0;
      rd_exp = 0; rd_kn = 1; rd_tag = "R9";
    end else begin
      o_v = s1_v; o_x = s1_x; o_y = s1_y; o_sof = s1_sof; o_pg = s1_pg;
      o_pix = s1_pix; o_kn = s1_kn; o_tag = s1_tag;
      off = int'(cpu_addr) % SPAN;
      pg = int'(cpu_addr) / SPAN;
      widx = (cpu_we && off < NPIX) ? pg * NPIX + off : -1;
      eff = (m_pos == 0) ? int'(page_sel) : m_cur;
      idx = eff * NPIX + m_pos;
      s1_v = 1; s1_x = m_pos % W; s1_y = m_pos / W; s1_sof = (m_pos == 0);
      s1_pg = eff; s1_pix = mm[idx]; s1_kn = kn[idx];
      s1_tag = (idx == widx) ? "R7" : (eff == 1 ? "R5" : "R6");
      m_cur = eff;
      m_pos = (m_pos + 1) % NPIX;
      if (off < NPIX) begin
        rd_exp = mm[pg * NPIX + off];
        rd_kn = kn[pg * NPIX + off];
        rd_tag = cpu_we ? "R7" : "R2";
        if (cpu_we) begin
          mm[pg * NPIX + off] = int'(cpu_wdata);
          kn[pg * NPIX + off] = 1;
        end
      end else begin
        rd_exp = 0; rd_kn = 1; rd_tag = "R3";
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(o_v ? "R4 valid" : "R9 valid", int'(disp_valid), int'(o_v));
      if (o_v) begin
        check("R4 x", int'(disp_x), o_x);
        check("R4 y", int'(disp_y), o_y);
        check("R4 sof", int'(disp_sof), int'(o_sof));
        check("R5 page", int'(disp_page), o_pg);
        if (o_kn) begin
          check({o_tag, " pixel"}, int'(disp_pix), o_pix);
          check("R8 rgb", int'(disp_rgb), ref_rgb(o_pix));
        end
      end
      if (rd_kn) check({rd_tag, " cpu read"}, int'(cpu_rdata), rd_exp);
    end
  end

  int seed = 32'h1234_5678;
  function automatic int nxt();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff_ffff;
  endfunction

  task automatic cyc(input int a, input bit we, input int d);
    @(negedge clk);
    #1;
    cpu_addr = AW'(a);
    cpu_we = we;
    cpu_wdata = PB'(d);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      r = nxt();
      if (r % 23 == 0) page_sel = ~page_sel;
      cyc(nxt() % (2 * SPAN), (nxt() % 3) != 0, nxt() % 4);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: address width from the pixel count plus the page bit
    check("R1 addr width", $bits(cpu_addr), $clog2(NPIX) + 1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2: fill both pages
    for (int i = 0; i < NPIX; i++) cyc(i, 1, (i * 3) % 4);
    for (int i = 0; i < NPIX; i++) cyc(SPAN + i, 1, (i + 1) % 4);
    cyc(0, 0, 0);
    repeat (2 * NPIX) cyc(SPAN + 7, 0, 0);
    // R6: draw into page 1 while page 0 is shown
    for (int i = 0; i < NPIX; i++) cyc(SPAN + i, 1, 3 - (i % 4));
    repeat (NPIX) cyc(3, 0, 0);
    // R5: request page 1 mid-frame, shown from next frame
    page_sel = 1'b1;
    repeat (2 * NPIX) cyc(4, 0, 0);
    // R3: offsets without storage
    cyc(NPIX, 1, 3);
    cyc(NPIX + 1, 1, 2);
    cyc(SPAN + NPIX, 1, 1);
    cyc(SPAN + NPIX + 1, 1, 3);
    cyc(NPIX, 0, 0);
    cyc(NPIX + 1, 0, 0);
    cyc(SPAN + NPIX, 0, 0);
    cyc(SPAN + NPIX + 1, 0, 0);
    cyc(0, 0, 0);
    // R7 and mixed traffic
    random_run(600);
    // R9: reset in the middle of a frame
    cyc(5, 0, 0);
    rst = 1'b1;
    repeat (3) cyc(5, 0, 0);
    rst = 1'b0;
    random_run(400);
    repeat (4) cyc(0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule